// File: doc/BRIEF.md
# NAND Chunk Hamming Code Generator

This block sits beside the data port of a NAND flash controller. As data bytes pass through the port, it builds a single-error-correcting Hamming code over every 256-byte chunk. The code is three bytes long and can locate one flipped bit anywhere in the chunk. Two parity families make up the code. Line parity tracks the byte index within the chunk. Column parity tracks the bit position within each byte.

Software writes the control register once before each chunk. A write of 0x07 clears the accumulator, turns accumulation on and selects inverted parity. After the chunk has passed, software reads the code back. It can read the three code bytes one at a time. It can also fetch all three, together with a controller status byte, in one 32-bit word. Correction and syndrome decoding are done elsewhere.

Top module: `nand_ecc_gen`

## Requirements
- R1: A byte is accumulated only in a cycle where `dataValid` is high, accumulation is enabled, and fewer than 256 bytes have been taken since the last clear. In any other cycle, no code byte changes.
- R2: For each byte index bit k (0..7), there are two line-parity bits. One holds the XOR of every data bit of the bytes whose index has bit k set. The other holds the same XOR for the bytes whose index has bit k clear. The low code byte holds index bits 0..3 and the high code byte holds index bits 4..7. Within each byte, pair k uses bit 2k for the "clear" half and bit 2k+1 for the "set" half. The first byte after a clear has index 0.
- R3: The column byte holds six parity bits in bits 7:2. For each group g (0..2), it holds the XOR over all accumulated bytes of the data bits whose bit position has bit g set (bit 2g+3) or clear (bit 2g+2). Bits 1:0 of the column byte always read 1.
- R4: When the polarity field is 1, all 22 parity bits read inverted. A chunk of 256 bytes of 0xFF then reads 0xFF in all three code bytes. With polarity 0, the same chunk reads 0x00, 0x00 and 0x03.
- R5: The control write data has three fields: bit 0 enables accumulation, bit 1 clears the accumulator, and bit 2 selects polarity. The enable and polarity fields are loaded on every control write.
- R6: A clear zeroes all parity bits and resets the byte index to 0. A data byte in the same cycle as a clear is discarded.
- R7: After the 256th byte, further bytes are ignored and the code is held until the next clear.
- R8: The read port works as follows:
  - `rdAddr` 1, 2 and 3 return the low, high and column code bytes, zero-extended to 32 bits.
  - `rdAddr` 0 returns {column, high, low, `statusByte`}, with the column byte in bits 31:24.
  - `rdAddr` 4 to 7 return 0.
- R9: After reset, accumulation is off, polarity is 0 and the byte index is 0. The code bytes read 0x00, 0x00 and 0x03.
- R10: A control write without clear changes the enable and polarity fields from the next cycle on. A data byte in the same cycle is governed by the enable value from before the write. A polarity change inverts the held code bytes without touching the accumulated parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dataValid | input | 1 | A data-port byte transfer happens this cycle |
| dataByte | input | 8 | Byte on the data port |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 3 | Control fields: bit 2 polarity, bit 1 clear, bit 0 enable |
| statusByte | input | 8 | Controller status placed in bits 7:0 of the packed read |
| rdAddr | input | 3 | Read select: 0 packed, 1 low, 2 high, 3 column |
| rdData | output | 32 | Read data |

## Verification
Three situations are hard to reach from the ports. The first is the end of a chunk: the code must freeze after exactly 256 accepted bytes. The second is a control write that lands in the same cycle as a data byte. The third is that only the index parities for specific byte positions show whether the index counter restarted. To reach the first, the stimulus runs full 256-byte chunks with random idle gaps and then keeps pushing bytes past the end. For the second, it issues control writes together with a byte, once with the clear field set and once with only the enable field set. For the third, it places single odd-parity bytes at index 0 and index 1. Their effect on the low and high code bytes is distinct and known in advance.

// File: rtl/nand_ecc_pkg.sv
`timescale 1ns/100ps
package nand_ecc_pkg;
  localparam int ECC_CHUNK  = 256;
  localparam int ECC_IDX_W  = $clog2(ECC_CHUNK);
  localparam int ECC_CNT_W  = ECC_IDX_W + 1;
  localparam int ECC_DATA_W = 8;
  localparam int ECC_GRP    = $clog2(ECC_DATA_W);
  localparam int ECC_LINE_W = 2 * ECC_IDX_W;
  localparam int ECC_COLP_W = 2 * ECC_GRP;
  localparam int ECC_HALF_W = ECC_LINE_W / 2;
  localparam int ECC_CTL_W  = 3;
  localparam int ECC_RD_W   = 32;
  localparam int ECC_ADDR_W = 3;

  // control field positions
  localparam int CTL_EN  = 0;
  localparam int CTL_CLR = 1;
  localparam int CTL_POL = 2;

  typedef struct packed {
    logic                 clearAcc;
    logic                 takeByte;
    logic                 invert;
    logic [ECC_IDX_W-1:0] byteIdx;
  } eccStrobe_t;

  // bit positions of a data byte whose index has bit g set
  function automatic logic [ECC_DATA_W-1:0] groupMask(input int g);
    logic [ECC_DATA_W-1:0] m;
    for (int b = 0; b < ECC_DATA_W; b++) m[b] = ((b >> g) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/nand_ecc_ctrl.sv
`timescale 1ns/100ps
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dataValid,
  input  logic                 ctlWrEn,
  input  logic [ECC_CTL_W-1:0] ctlWrData,
  output eccStrobe_t           strobe
);
  logic                 accEnable;
  logic                 polSel;
  logic [ECC_CNT_W-1:0] byteCount;
  logic                 clearReq;
  logic                 chunkFull;
  logic                 takeReq;

  always_comb begin
    clearReq  = ctlWrEn & ctlWrData[CTL_CLR];
    chunkFull = (byteCount == ECC_CNT_W'(ECC_CHUNK));
    takeReq   = dataValid & accEnable & ~chunkFull & ~clearReq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accEnable <= 1'b0;
      polSel    <= 1'b0;
      byteCount <= '0;
    end else begin
      if (clearReq)     byteCount <= '0;
      else if (takeReq) byteCount <= byteCount + 1'b1;
      if (ctlWrEn) begin
        accEnable <= ctlWrData[CTL_EN];
        polSel    <= ctlWrData[CTL_POL];
      end
    end
  end

  always_comb begin
    strobe.clearAcc = clearReq;
    strobe.takeByte = takeReq;
    strobe.invert   = polSel;
    strobe.byteIdx  = byteCount[ECC_IDX_W-1:0];
  end
endmodule

// File: rtl/nand_ecc_dpath.sv
`timescale 1ns/100ps
module nand_ecc_dpath
  import nand_ecc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  eccStrobe_t            strobe,
  input  logic [ECC_DATA_W-1:0] dataByte,
  input  logic [ECC_DATA_W-1:0] statusByte,
  input  logic [ECC_ADDR_W-1:0] rdAddr,
  output logic [ECC_DATA_W-1:0] lowByte,
  output logic [ECC_DATA_W-1:0] highByte,
  output logic [ECC_DATA_W-1:0] colByte,
  output logic [ECC_RD_W-1:0]   rdData
);
  localparam int PAD_W = ECC_DATA_W - ECC_COLP_W;
  localparam logic [ECC_ADDR_W-1:0] RD_PACKED = 3'd0;
  localparam logic [ECC_ADDR_W-1:0] RD_LOW    = 3'd1;
  localparam logic [ECC_ADDR_W-1:0] RD_HIGH   = 3'd2;
  localparam logic [ECC_ADDR_W-1:0] RD_COL    = 3'd3;

  logic [ECC_LINE_W-1:0] lineAcc, lineTerm, lineOut;
  logic [ECC_COLP_W-1:0] colAcc, colTerm;
  logic                  byteParity;

  assign byteParity = ^dataByte;

  for (genvar k = 0; k < ECC_IDX_W; k++) begin : g_line
    assign lineTerm[2*k+1] = byteParity &  strobe.byteIdx[k];
    assign lineTerm[2*k]   = byteParity & ~strobe.byteIdx[k];
  end

  for (genvar g = 0; g < ECC_GRP; g++) begin : g_col
    assign colTerm[2*g+1] = ^(dataByte &  groupMask(g));
    assign colTerm[2*g]   = ^(dataByte & ~groupMask(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clearAcc) begin
      lineAcc <= '0;
      colAcc  <= '0;
    end else if (strobe.takeByte) begin
      lineAcc <= lineAcc ^ lineTerm;
      colAcc  <= colAcc ^ colTerm;
    end
  end

  always_comb begin
    lineOut  = lineAcc ^ {ECC_LINE_W{strobe.invert}};
    lowByte  = lineOut[ECC_HALF_W-1:0];
    highByte = lineOut[ECC_LINE_W-1:ECC_HALF_W];
    colByte  = {colAcc ^ {ECC_COLP_W{strobe.invert}}, {PAD_W{1'b1}}};
  end

  always_comb begin
    case (rdAddr)
      RD_PACKED: rdData = {colByte, highByte, lowByte, statusByte};
      RD_LOW:    rdData = ECC_RD_W'(lowByte);
      RD_HIGH:   rdData = ECC_RD_W'(highByte);
      RD_COL:    rdData = ECC_RD_W'(colByte);
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/nand_ecc_gen.sv
`timescale 1ns/100ps
module nand_ecc_gen
  import nand_ecc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dataValid,
  input  logic [ECC_DATA_W-1:0] dataByte,
  input  logic                  ctlWrEn,
  input  logic [ECC_CTL_W-1:0]  ctlWrData,
  input  logic [ECC_DATA_W-1:0] statusByte,
  input  logic [ECC_ADDR_W-1:0] rdAddr,
  output logic [ECC_RD_W-1:0]   rdData
);
  eccStrobe_t            strobe;
  logic [ECC_DATA_W-1:0] lowByte, highByte, colByte;

  nand_ecc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dataValid (dataValid),
    .ctlWrEn   (ctlWrEn),
    .ctlWrData (ctlWrData),
    .strobe    (strobe)
  );

  nand_ecc_dpath u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .dataByte   (dataByte),
    .statusByte (statusByte),
    .rdAddr     (rdAddr),
    .lowByte    (lowByte),
    .highByte   (highByte),
    .colByte    (colByte),
    .rdData     (rdData)
  );
endmodule

// File: rtl/nand_ecc_gen_chk.sv
`timescale 1ns/100ps
module nand_ecc_gen_chk
  import nand_ecc_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dataValid,
  input logic                  ctlWrEn,
  input logic [ECC_CTL_W-1:0]  ctlWrData,
  input logic [ECC_DATA_W-1:0] lowByte,
  input logic [ECC_DATA_W-1:0] highByte,
  input logic [ECC_DATA_W-1:0] colByte
);
  // shadow of enable and chunk fill, tracked from the ports
  logic                 shEn;
  logic [ECC_CNT_W-1:0] shCnt;
  logic                 shFull;
  assign shFull = (shCnt == ECC_CNT_W'(ECC_CHUNK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shEn  <= 1'b0;
      shCnt <= '0;
    end else begin
      if (ctlWrEn && ctlWrData[CTL_CLR]) shCnt <= '0;
      else if (dataValid && shEn && !shFull) shCnt <= shCnt + 1'b1;
      if (ctlWrEn) shEn <= ctlWrData[CTL_EN];
    end
  end

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctlWrEn && ctlWrData[CTL_CLR] && !ctlWrData[CTL_POL]
    |=> lowByte == 8'h00 && highByte == 8'h00 && colByte == 8'h03);

  // R4
  clear_erased_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctlWrEn && ctlWrData[CTL_CLR] && ctlWrData[CTL_POL]
    |=> lowByte == 8'hFF && highByte == 8'hFF && colByte == 8'hFF);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctlWrEn && !dataValid
    |=> $stable(lowByte) && $stable(highByte) && $stable(colByte));

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shFull && !ctlWrEn
    |=> $stable(lowByte) && $stable(highByte) && $stable(colByte));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dataValid (dataValid),
  .ctlWrEn   (ctlWrEn),
  .ctlWrData (ctlWrData),
  .lowByte   (lowByte),
  .highByte  (highByte),
  .colByte   (colByte)
);

// File: tb/nand_ecc_gen_tb.sv
`timescale 1ns/100ps
module nand_ecc_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dataValid = 1'b0;
  logic [7:0]  dataByte = 8'h00;
  logic        ctlWrEn = 1'b0;
  logic [2:0]  ctlWrData = 3'b000;
  logic [7:0]  statusByte = 8'hA5;
  logic [2:0]  rdAddr = 3'd0;
  logic [31:0] rdData;

  int nChecks = 0;
  int nErrors = 0;

  // behavioural reference state
  bit        mEn = 0, mPol = 0;
  int        mCnt = 0;
  bit [15:0] mLine = '0;
  bit [5:0]  mCol = '0;

  always #4 clk = ~clk;

  nand_ecc_gen u_dut (
    .clk(clk), .rst_n(rst_n), .dataValid(dataValid), .dataByte(dataByte),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .statusByte(statusByte),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic bit [31:0] expRead(input int sel);
    bit [7:0] lo, hi, co;
    lo = mLine[7:0]  ^ {8{mPol}};
    hi = mLine[15:8] ^ {8{mPol}};
    co = {mCol ^ {6{mPol}}, 2'b11};
    case (sel)
      0: return {co, hi, lo, statusByte};
      1: return {24'h0, lo};
      2: return {24'h0, hi};
      3: return {24'h0, co};
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelEdge();
    bit clr, take, p;
    if (!rst_n) begin
      mEn = 0; mPol = 0; mCnt = 0; mLine = '0; mCol = '0;
      return;
    end
    clr  = ctlWrEn && ctlWrData[1];
    take = dataValid && mEn && (mCnt < 256) && !clr;
    if (take) begin
      p = ($countones(dataByte) % 2) == 1;
      for (int k = 0; k < 8; k++) begin
        if (((mCnt >> k) & 1) == 1) mLine[2*k+1] ^= p;
        else                        mLine[2*k]   ^= p;
      end
      for (int g = 0; g < 3; g++)
        for (int b = 0; b < 8; b++) begin
          if (((b >> g) & 1) == 1) mCol[2*g+1] ^= dataByte[b];
          else                     mCol[2*g]   ^= dataByte[b];
        end
      mCnt++;
    end
    if (clr) begin
      mLine = '0; mCol = '0; mCnt = 0;
    end
    if (ctlWrEn) begin
      mEn  = ctlWrData[0];
      mPol = ctlWrData[2];
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s rdAddr=%0d actual=%08h expected=%08h", tag, rdAddr, got, exp);
    end
  endtask

  // one clock: advance model, then compare every read address
  task automatic tick(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rdAddr = 3'(a);
      #0.2;
      check(tag, rdData, expRead(a));
    end
  endtask

  task automatic readAt(input string tag, input int a, input logic [31:0] exp);
    rdAddr = 3'(a);
    #0.1;
    check(tag, rdData, exp);
  endtask

  task automatic ctl(input logic [2:0] d);
    ctlWrEn = 1'b1; ctlWrData = d;
    tick("R5");
    ctlWrEn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input string tag);
    dataValid = 1'b1; dataByte = b;
    tick(tag);
    dataValid = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    #1600000;
    nErrors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick("R9");
    // R9 reset state
    readAt("R9", 0, 32'h030000A5);
    readAt("R9", 3, 32'h00000003);

    // R4 erased chunk with polarity set
    ctl(3'b111);
    for (int i = 0; i < 256; i++) sendByte(8'hFF, "R4");
    readAt("R4", 1, 32'hFF);
    readAt("R4", 2, 32'hFF);
    readAt("R4", 3, 32'hFF);
    readAt("R8", 0, 32'hFFFFFFA5);

    // R7 extra bytes after chunk end
    for (int i = 0; i < 20; i++) sendByte(8'h5A, "R7");
    readAt("R7", 0, 32'hFFFFFFA5);

    // R4 same chunk, polarity 0
    ctl(3'b011);
    for (int i = 0; i < 256; i++) sendByte(8'hFF, "R4");
    readAt("R4", 0, 32'h030000A5);

    // R2 R3 single byte at index 0, then at index 1
    ctl(3'b011);
    sendByte(8'h01, "R2");
    readAt("R2", 1, 32'h55);
    readAt("R2", 2, 32'h55);
    readAt("R3", 3, 32'h57);
    sendByte(8'h01, "R2");
    readAt("R2", 1, 32'h03);
    readAt("R2", 2, 32'h00);
    readAt("R3", 3, 32'h03);

    // R6 clear with same-cycle byte: byte dropped, index back to 0
    dataValid = 1'b1; dataByte = 8'hFE;
    ctl(3'b011);
    dataValid = 1'b0;
    readAt("R6", 0, 32'h030000A5);
    sendByte(8'h80, "R6");
    readAt("R6", 1, 32'h55);
    readAt("R3", 3, 32'hAB);

    // R1 disabled: bytes ignored
    ctl(3'b000);
    for (int i = 0; i < 5; i++) sendByte(8'h13, "R1");
    readAt("R1", 1, 32'h55);

    // R10 polarity flip without clear
    ctl(3'b100);
    readAt("R10", 1, 32'hAA);
    readAt("R10", 3, 32'h57);

    // R10 enable write with same-cycle byte uses old enable (off)
    dataValid = 1'b1; dataByte = 8'h01;
    ctl(3'b001);
    dataValid = 1'b0;
    readAt("R10", 1, 32'h55);
    readAt("R10", 2, 32'h55);

    // R8 unused read addresses
    for (int a = 4; a < 8; a++) readAt("R8", a, 32'h0);

    // R2 random chunks with gaps, compared every cycle
    ctl(3'b111);
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 4) == 0) tick("R1");
      statusByte = 8'($urandom);
      sendByte(8'($urandom), "R2");
    end
    ctl(3'b011);
    for (int i = 0; i < 120; i++) sendByte(8'($urandom), "R3");

    summary();
  end
endmodule